// File: doc/BRIEF.md
# Channelized Serial Port Timeslot Extractor

This block sits on the receive side of a serial line port. It accepts one data bit per qualified clock, along with an optional frame sync. It cuts the stream into 8-bit timeslots and delivers each kept slot as a parallel value with its slot number. The port runs in one of two modes:

- **Channelized mode.** A sync pulse, recurring once per frame, anchors the frame. The frame holds 24, 32, 64 or 128 slots. The 24-slot size carries one extra framing bit at its head, and that bit is thrown away.
- **Unchannelized mode.** The sync input plays no part. Every eight accepted bits leave the block as one clear-channel byte.

A 2-bit entry per slot selects full 8-bit capture, capture of the seven upper bits only, or no capture. Software writes a shadow copy of this table. The copy becomes live at the next frame start. The counters track frame alignment. A late or early sync pulse sets a sticky error flag and realigns the counters.

Top module: `tdm_slot_extractor`

## Requirements
- R1: After reset, byte_vld_o, byte_o, byte_7b_o, slot_o and sync_err_o are 0. Every slot table entry reads as 2'b00 (drop), so a channelized frame produces no strobe until entries are written.
- R2: In channelized mode, the accepted bit with sync_i high is the first bit of a frame. Bits enter MSB first. One cycle after a slot's eighth accepted bit, byte_vld_o pulses for one cycle with that slot's number on slot_o.
- R3: frame_size_i selects the frame size: 0 gives 24 slots, 1 gives 32, 2 gives 64 and 3 gives 128. After the last slot, counting returns to slot 0.
- R4: With frame_size_i = 0, the first accepted bit of each frame is a framing bit and produces no data. The frame is 193 bits long.
- R5: Slot entry codes are as follows. 2'b01 gives byte_o = all 8 bits and byte_7b_o = 0. 2'b10 gives byte_o = {1'b0, seven upper bits} and byte_7b_o = 1, with the least significant bit dropped. 2'b00 and 2'b11 give no strobe.
- R6: A write with cfg_we_i updates the shadow entry cfg_addr_i. The live entry takes the new value only at the next frame start, whether that start comes from a sync or from a wrap.
- R7: Once a sync has been seen, a frame start with no sync on its first bit sets sync_err_o. The counters still wrap, and the data stays aligned.
- R8: A sync on any bit other than a frame's first bit sets sync_err_o, discards the partial slot, and restarts the frame at that bit.
- R9: sync_err_o stays set while enable_i is high. When enable_i is low, sync_err_o clears on the next clock edge and the counters return to the frame start.
- R10: In unchannelized mode, sync_i and the slot table are ignored. A full byte with slot_o = 0 and byte_7b_o = 0 comes out every 8 accepted bits, counted from enable. sync_err_o stays 0.
- R11: Cycles with bit_vld_i low do not advance any counter and produce no strobe, whatever data_i and sync_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Port enable; low clears counters and error flag |
| chan_mode_i | input | 1 | 1 = channelized, 0 = unchannelized |
| frame_size_i | input | 2 | Frame size code (24/32/64/128 slots) |
| bit_vld_i | input | 1 | Qualifies data_i and sync_i this cycle |
| data_i | input | 1 | Serial data bit |
| sync_i | input | 1 | Frame sync, high on the first bit of a frame |
| cfg_we_i | input | 1 | Slot table write strobe |
| cfg_addr_i | input | SLOT_W | Slot table write address |
| cfg_data_i | input | 2 | Slot table entry code |
| byte_vld_o | output | 1 | Output value strobe |
| byte_o | output | 8 | Captured slot value |
| byte_7b_o | output | 1 | 1 when byte_o holds a 7-bit value |
| slot_o | output | SLOT_W | Slot number of byte_o |
| sync_err_o | output | 1 | Sticky frame alignment error |

## Verification
The hardest situations to reach from the ports are a table write that lands in the middle of a frame and a sync that arrives partway through a slot.

- **Mid-frame table write.** The frame driver pauses after the middle slot and issues the write. Under R6, the write must not change a later slot of the same frame, yet it must change that slot in the following frame.
- **Early sync.** A partial frame is cut off four bits into its third slot by the sync of a fresh frame. The scoreboard then expects the half-built slot to vanish and the following frame to come out aligned.
- **Idle cycles.** Random idle cycles, carrying noise on the data and sync inputs, are mixed into some frames to show that only qualified bits count.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic [1:0] {
    CFG_DROP  = 2'b00,
    CFG_FULL  = 2'b01,
    CFG_MSB7  = 2'b10,
    CFG_DROP2 = 2'b11
  } slot_cfg_e;

  typedef enum logic [1:0] {
    FS_24  = 2'd0,
    FS_32  = 2'd1,
    FS_64  = 2'd2,
    FS_128 = 2'd3
  } frame_size_e;

  function automatic int unsigned last_slot(input logic [1:0] fs);
    case (fs)
      FS_24:   return 23;
      FS_32:   return 31;
      FS_64:   return 63;
      default: return 127;
    endcase
  endfunction
endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_vld_i,
  input  logic              chan_i,
  input  logic              sync_i,
  input  logic [1:0]        size_i,
  output logic              proc_o,
  output logic [2:0]        bit_idx_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_start_o,
  output logic              err_o
);
  logic [2:0]        bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              fbit_q, synced_q, err_q;

  logic              take, is24, restart, at_start, cur_fbit;
  logic [2:0]        cur_bit;
  logic [SLOT_W-1:0] cur_slot, last;

  always_comb begin
    take     = bit_vld_i & en_i;
    is24     = chan_i & (size_i == FS_24);
    restart  = chan_i & sync_i;
    last     = SLOT_W'(last_slot(size_i));
    at_start = (slot_q == '0) && (bit_q == 3'd0) && (fbit_q == is24);
    cur_fbit = restart ? is24 : fbit_q;
    cur_bit  = restart ? 3'd0 : bit_q;
    cur_slot = restart ? '0   : slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      slot_q   <= '0;
      fbit_q   <= 1'b0;
      synced_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (!en_i) begin
      bit_q    <= '0;
      slot_q   <= '0;
      fbit_q   <= 1'b0;
      synced_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (take) begin
      if (restart) synced_q <= 1'b1;
      // late (missing) or early sync once aligned
      if (chan_i && synced_q && (restart != at_start)) err_q <= 1'b1;
      if (cur_fbit) begin
        fbit_q <= 1'b0;
        bit_q  <= 3'd0;
        slot_q <= '0;
      end else if (cur_bit == 3'd7) begin
        bit_q <= 3'd0;
        if (chan_i && cur_slot == last) begin
          slot_q <= '0;
          fbit_q <= is24;
        end else begin
          slot_q <= chan_i ? cur_slot + 1'b1 : '0;
          fbit_q <= 1'b0;
        end
      end else begin
        bit_q  <= cur_bit + 3'd1;
        slot_q <= cur_slot;
        fbit_q <= 1'b0;
      end
    end
  end

  assign proc_o        = take & ~cur_fbit;
  assign bit_idx_o     = cur_bit;
  assign slot_o        = cur_slot;
  assign frame_start_o = take & chan_i & (restart | at_start);
  assign err_o         = err_q;
endmodule

// File: rtl/tdm_slot_cfg.sv
module tdm_slot_cfg #(
  parameter int SLOTS  = 128,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [1:0]        wdata_i,
  input  logic              commit_i,
  input  logic [SLOT_W-1:0] raddr_i,
  output logic [1:0]        rdata_o
);
  logic [1:0] shadow_q [SLOTS];
  logic [1:0] live_q   [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) shadow_q[i] <= 2'b00;
    end else if (we_i) begin
      shadow_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) live_q[i] <= 2'b00;
    end else if (commit_i) begin
      for (int i = 0; i < SLOTS; i++) live_q[i] <= shadow_q[i];
    end
  end

  assign rdata_o = live_q[raddr_i];
endmodule

// File: rtl/tdm_byte_pack.sv
module tdm_byte_pack
  import tdm_rx_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_i,
  input  logic              data_i,
  input  logic [2:0]        bit_idx_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              chan_i,
  input  logic [1:0]        cfg_i,
  output logic              vld_o,
  output logic [7:0]        byte_o,
  output logic              w7_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [6:0] sh_q;
  logic [1:0] mode;

  assign mode = chan_i ? cfg_i : CFG_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      vld_o  <= 1'b0;
      byte_o <= '0;
      w7_o   <= 1'b0;
      slot_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (proc_i) begin
        sh_q <= {sh_q[5:0], data_i};
        if (bit_idx_i == 3'd7) begin
          case (mode)
            CFG_FULL: begin
              vld_o  <= 1'b1;
              byte_o <= {sh_q, data_i};
              w7_o   <= 1'b0;
              slot_o <= slot_i;
            end
            CFG_MSB7: begin
              vld_o  <= 1'b1;
              byte_o <= {1'b0, sh_q};
              w7_o   <= 1'b1;
              slot_o <= slot_i;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_extractor.sv
module tdm_slot_extractor
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS = 128,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              chan_mode_i,
  input  logic [1:0]        frame_size_i,
  input  logic              bit_vld_i,
  input  logic              data_i,
  input  logic              sync_i,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_addr_i,
  input  logic [1:0]        cfg_data_i,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o,
  output logic              byte_7b_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sync_err_o
);
  logic              proc, frame_start;
  logic [2:0]        bit_idx;
  logic [SLOT_W-1:0] cur_slot;
  logic [1:0]        slot_cfg;

  tdm_frame_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (enable_i),
    .bit_vld_i    (bit_vld_i),
    .chan_i       (chan_mode_i),
    .sync_i       (sync_i),
    .size_i       (frame_size_i),
    .proc_o       (proc),
    .bit_idx_o    (bit_idx),
    .slot_o       (cur_slot),
    .frame_start_o(frame_start),
    .err_o        (sync_err_o)
  );

  tdm_slot_cfg #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_data_i),
    .commit_i(frame_start),
    .raddr_i (cur_slot),
    .rdata_o (slot_cfg)
  );

  tdm_byte_pack #(.SLOT_W(SLOT_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .proc_i   (proc),
    .data_i   (data_i),
    .bit_idx_i(bit_idx),
    .slot_i   (cur_slot),
    .chan_i   (chan_mode_i),
    .cfg_i    (slot_cfg),
    .vld_o    (byte_vld_o),
    .byte_o   (byte_o),
    .w7_o     (byte_7b_o),
    .slot_o   (slot_o)
  );
endmodule

// File: rtl/tdm_slot_extractor_chk.sv
module tdm_slot_extractor_chk #(
  parameter int SLOT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              chan_mode_i,
  input logic [1:0]        frame_size_i,
  input logic              bit_vld_i,
  input logic              byte_vld_o,
  input logic [7:0]        byte_o,
  input logic              byte_7b_o,
  input logic [SLOT_W-1:0] slot_o,
  input logic              sync_err_o
);
  assert_strobe_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_vld_i && enable_i));

  assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o && $past(chan_mode_i) && $past(frame_size_i) == 2'd0 |-> slot_o < SLOT_W'(24));

  assert_msb7_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o && byte_7b_o |-> byte_o[7] == 1'b0);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && $past(enable_i) && $past(sync_err_o) |-> sync_err_o);

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !sync_err_o);

  assert_unchan_slot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o && !$past(chan_mode_i) |-> slot_o == '0 && !byte_7b_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !byte_vld_o);
endmodule

bind tdm_slot_extractor tdm_slot_extractor_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .chan_mode_i (chan_mode_i),
  .frame_size_i(frame_size_i),
  .bit_vld_i   (bit_vld_i),
  .byte_vld_o  (byte_vld_o),
  .byte_o      (byte_o),
  .byte_7b_o   (byte_7b_o),
  .slot_o      (slot_o),
  .sync_err_o  (sync_err_o)
);

// File: tb/sim_tdm_slot_extractor.sv
`timescale 1ns/1ps
module sim_tdm_slot_extractor;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       enable = 0, chan = 0, bit_vld = 0, data = 0, sync = 0, cfg_we = 0;
  logic [1:0] fsize = 0, cfg_data = 0;
  logic [6:0] cfg_addr = 0;
  logic       byte_vld, byte_7b, sync_err;
  logic [7:0] byte_v;
  logic [6:0] slot_v;

  typedef struct {
    logic [6:0] slot;
    logic [7:0] val;
    logic       w7;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_run = 0, n_fail = 0;
  logic [1:0] shadow_m [128];
  logic [1:0] live_m   [128];
  bit         gap_mode = 0;

  always #2.5 clk = ~clk;

  tdm_slot_extractor u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .chan_mode_i(chan),
    .frame_size_i(fsize), .bit_vld_i(bit_vld), .data_i(data), .sync_i(sync),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .byte_vld_o(byte_vld), .byte_o(byte_v), .byte_7b_o(byte_7b),
    .slot_o(slot_v), .sync_err_o(sync_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare each strobe
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && byte_vld) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5", "unexpected strobe", {byte_7b, slot_v, byte_v}, 16'h0);
      end else begin
        e = sb.pop_front();
        chk(slot_v == e.slot && byte_v == e.val && byte_7b == e.w7, e.tag,
            "slot value", {byte_7b, slot_v, byte_v}, {e.w7, e.slot, e.val});
      end
    end
  end

  function automatic logic [7:0] slot_val(input int s, input int k);
    return 8'(s * 37 + k * 11 + 5);
  endfunction

  function automatic int n_slots(input logic [1:0] f);
    case (f)
      2'd0: return 24;
      2'd1: return 32;
      2'd2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic push_exp(input int s, input logic [7:0] v, input string tag);
    exp_t e;
    e.slot = 7'(s); e.tag = tag;
    if (live_m[s] == 2'b01) begin
      e.val = v; e.w7 = 1'b0; sb.push_back(e);
    end else if (live_m[s] == 2'b10) begin
      e.val = {1'b0, v[7:1]}; e.w7 = 1'b1; sb.push_back(e);
    end
  endtask

  task automatic send_bit(input logic d, input logic s);
    if (gap_mode && ($urandom % 3 == 0)) begin
      @(negedge clk); bit_vld = 0; data = 1'($urandom); sync = 1'($urandom);
    end
    @(negedge clk); bit_vld = 1; data = d; sync = s;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); bit_vld = 0; sync = 0; data = 0;
    end
  endtask

  task automatic cfg_write(input int a, input logic [1:0] v);
    @(negedge clk); bit_vld = 0; sync = 0;
    cfg_we = 1; cfg_addr = 7'(a); cfg_data = v;
    shadow_m[a] = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_mode(input logic c, input logic [1:0] f);
    @(negedge clk); enable = 0; bit_vld = 0; sync = 0;
    @(negedge clk);
    chk(sync_err == 1'b0, "R9", "error cleared by disable", 16'(sync_err), 16'h0);
    chan = c; fsize = f; enable = 1;
  endtask

  // one frame; optional shadow write after the middle slot
  task automatic send_frame(input logic [1:0] f, input int k, input bit with_sync,
                            input string tag, input bit wr, input int wa, input logic [1:0] wv);
    bit   first;
    int   n;
    logic [7:0] v;
    n = n_slots(f);
    for (int i = 0; i < 128; i++) live_m[i] = shadow_m[i];
    first = 1;
    if (f == 2'd0) begin
      send_bit(1'b1, with_sync);
      first = 0;
    end
    for (int s = 0; s < n; s++) begin
      v = slot_val(s, k);
      push_exp(s, v, tag);
      for (int b = 7; b >= 0; b--) begin
        send_bit(v[b], first && with_sync);
        first = 0;
      end
      if (wr && s == n / 2 - 1) cfg_write(wa, wv);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      shadow_m[i] = 2'b00;
      live_m[i]   = 2'b00;
    end
    repeat (3) @(negedge clk);
    chk(byte_vld == 0 && byte_v == 0 && byte_7b == 0 && slot_v == 0 && sync_err == 0,
        "R1", "reset outputs", {byte_vld, byte_7b, sync_err, slot_v, byte_v[4:0]}, 16'h0);
    rst_n = 1;

    // R1: empty table, nothing delivered
    set_mode(1'b1, 2'd1);
    send_frame(2'd1, 0, 1, "R1", 0, 0, 2'b00);
    idle(3);
    chk(sb.size() == 0, "R1", "no strobes with reset table", 16'(sb.size()), 16'h0);

    // R5: codes by slot modulo 4 (drop, full, msb7, drop alt)
    for (int a = 0; a < 128; a++) cfg_write(a, 2'(a % 4));

    set_mode(1'b1, 2'd1);
    send_frame(2'd1, 1, 1, "R2", 0, 0, 2'b00);
    gap_mode = 1;
    send_frame(2'd1, 2, 1, "R11", 0, 0, 2'b00);
    gap_mode = 0;
    // R6: mid-frame write of slot 20 must wait for next frame
    send_frame(2'd1, 3, 1, "R6", 1, 20, 2'b01);
    send_frame(2'd1, 4, 1, "R6", 0, 0, 2'b00);
    idle(3);
    chk(sync_err == 0, "R8", "aligned syncs raise no error", 16'(sync_err), 16'h0);

    // R7: missing sync
    send_frame(2'd1, 5, 0, "R7", 0, 0, 2'b00);
    idle(2);
    chk(sync_err == 1, "R7", "missing sync flag", 16'(sync_err), 16'h1);

    // R4: 24-slot frames with framing bit
    set_mode(1'b1, 2'd0);
    send_frame(2'd0, 6, 1, "R4", 0, 0, 2'b00);
    send_frame(2'd0, 7, 1, "R4", 0, 0, 2'b00);
    idle(2);
    chk(sync_err == 0, "R4", "193-bit frame alignment", 16'(sync_err), 16'h0);

    // R3: larger frame sizes and wrap
    set_mode(1'b1, 2'd2);
    send_frame(2'd2, 8, 1, "R3", 0, 0, 2'b00);
    set_mode(1'b1, 2'd3);
    send_frame(2'd3, 9, 1, "R3", 0, 0, 2'b00);
    send_frame(2'd3, 10, 1, "R3", 0, 0, 2'b00);
    idle(2);
    chk(sync_err == 0, "R3", "128-slot wrap aligned", 16'(sync_err), 16'h0);

    // R8: early sync four bits into slot 2
    set_mode(1'b1, 2'd1);
    send_frame(2'd1, 11, 1, "R8", 0, 0, 2'b00);
    for (int i = 0; i < 128; i++) live_m[i] = shadow_m[i];
    for (int s = 0; s < 2; s++) begin
      logic [7:0] v;
      v = slot_val(s, 12);
      push_exp(s, v, "R8");
      for (int b = 7; b >= 0; b--) send_bit(v[b], s == 0 && b == 7);
    end
    for (int b = 0; b < 4; b++) send_bit(1'b1, 1'b0);
    send_frame(2'd1, 13, 1, "R8", 0, 0, 2'b00);
    idle(2);
    chk(sync_err == 1, "R8", "early sync flag", 16'(sync_err), 16'h1);

    // R10: clear channel, sync noise and table ignored
    set_mode(1'b0, 2'd1);
    gap_mode = 1;
    for (int n = 0; n < 5; n++) begin
      logic [7:0] v;
      exp_t e;
      v = slot_val(n, 20);
      e.slot = 0; e.val = v; e.w7 = 0; e.tag = "R10";
      sb.push_back(e);
      for (int b = 7; b >= 0; b--) send_bit(v[b], 1'($urandom));
    end
    gap_mode = 0;
    idle(3);
    chk(sync_err == 0, "R10", "sync ignored when unchannelized", 16'(sync_err), 16'h0);

    idle(4);
    chk(sb.size() == 0, "R2", "all expected values delivered", 16'(sb.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule